// File: doc/BRIEF.md
# Reprogrammable Two-Digit Combination Lock

This block is a synchronous state machine guarding a door. A user presents a 2-bit code and pulses a one-cycle enter strobe, twice in a row. The block compares the two codes, in order, with a stored pair of digits. A match opens the lock. A mismatch raises an error indication, but only after the second digit has been taken, so that an observer learns nothing from the first entry alone.

While the lock is open, a further enter strobe starts reprogramming. The next two strobes load new first and second digits, and the lock then returns to the open condition with the new pair in force. A separate restore input loads the factory combination (first digit 2'b11, second digit 2'b01). The general reset returns the machine to idle but leaves the stored digits alone. All status flags are decoded from the registered state only. An 8-bit debug bus shows both stored digits and the state code.

Top module: `combo_lock_ctrl`

## Requirements
- R1: While `rst_n` is low and after its release, the state code is 0 (idle) and `open`, `error`, `prog1` and `prog2` are all low.
- R2: Asserting `rst_n` low returns the machine to idle and does not alter either stored digit.
- R3: A cycle with `combo_rst` high loads first digit 2'b11 and second digit 2'b01 and puts the machine in idle on the next edge. This holds even when `enter` is high in the same cycle, in any state.
- R4: From idle, an enter carrying the stored first digit followed by an enter carrying the stored second digit sets `open` high after the second edge.
- R5: When the first entered code is wrong, the machine stays silent (no flag high, state code 2) and accepts a second enter. It then raises `error` whatever the second code is.
- R6: A correct first digit followed by a wrong second digit raises `error`.
- R7: In the error state, `error` stays high without enter, and the next enter returns the machine to idle.
- R8: In the open state, `open` stays high while `enter` is low. An enter moves the machine to the first programming state with `prog1` high.
- R9: In the first programming state, enter stores `code` as the new first digit and raises `prog2`. In the second programming state, enter stores `code` as the new second digit and returns to open. Later entries are checked against the new pair.
- R10: At most one of `open`, `error`, `prog1` and `prog2` is high at a time. `dbg[7:6]` is the first digit, `dbg[5:4]` is the second digit, `dbg[3]` is 0, and `dbg[2:0]` is the state code: 0 idle, 1 first digit correct, 2 first digit wrong, 3 open, 4 error, 5 programming first digit, 6 programming second digit.
- R11: Cycles with `enter` and `combo_rst` both low change neither the state nor the stored digits, whatever `code` does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset of the state machine only |
| code | input | 2 | Digit presented by the user |
| enter | input | 1 | One-cycle strobe that takes `code` |
| combo_rst | input | 1 | Restores the default combination and returns to idle |
| open | output | 1 | Lock open |
| error | output | 1 | Wrong combination entered |
| prog1 | output | 1 | Waiting for the new first digit |
| prog2 | output | 1 | Waiting for the new second digit |
| dbg | output | 8 | Stored digits and state code |

## Verification
The hardest situations to reach are a restore request that coincides with a programming strobe, and a reset that lands just after a reprogramming. The bench first opens the lock and enters programming. It then raises `combo_rst` together with `enter`, and checks through `dbg` that the default digits won and that the state is idle. In a separate run it reprograms the pair, pulses `rst_n`, and shows from both the debug bus and a later failed entry with the old digits that the new pair survived the reset.

// File: rtl/combo_lock_pkg.sv
package combo_lock_pkg;

  localparam int unsigned ST_W = 3;

  typedef enum logic [ST_W-1:0] {
    ST_IDLE      = 3'd0,
    ST_FIRST_OK  = 3'd1,
    ST_FIRST_BAD = 3'd2,
    ST_OPEN      = 3'd3,
    ST_ERR       = 3'd4,
    ST_PROG1     = 3'd5,
    ST_PROG2     = 3'd6
  } lock_state_e;

endpackage

// File: rtl/combo_store.sv
// Stored digits. Deliberately untouched by the state-machine reset;
// only the restore input or a programming write changes them.
module combo_store #(
  parameter int unsigned DIGIT_W    = 2,
  parameter int unsigned NUM_DIGITS = 2,
  parameter logic [NUM_DIGITS*DIGIT_W-1:0] DEF_COMBO = 4'b0111
) (
  input  logic                                clk,
  input  logic                                combo_rst,
  input  logic [NUM_DIGITS-1:0]               wr_en,
  input  logic [DIGIT_W-1:0]                  code,
  output logic [NUM_DIGITS-1:0][DIGIT_W-1:0]  digits
);

  for (genvar g = 0; g < NUM_DIGITS; g++) begin : g_digit
    logic [DIGIT_W-1:0] dig_q;
    logic [DIGIT_W-1:0] dig_d;
    logic               dig_en;

    always_comb begin
      dig_en = combo_rst | wr_en[g];
      dig_d  = combo_rst ? DEF_COMBO[g*DIGIT_W +: DIGIT_W] : code;
    end

    always_ff @(posedge clk) begin
      if (dig_en) begin
        dig_q <= dig_d;
      end
    end

    assign digits[g] = dig_q;
  end

endmodule

// File: rtl/lock_fsm.sv
module lock_fsm
  import combo_lock_pkg::*;
#(
  parameter int unsigned DIGIT_W = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               enter,
  input  logic               combo_rst,
  input  logic [DIGIT_W-1:0] code,
  input  logic [DIGIT_W-1:0] dig_first,
  input  logic [DIGIT_W-1:0] dig_second,
  output lock_state_e        state,
  output logic [1:0]         wr_en
);

  lock_state_e state_q;
  lock_state_e state_d;
  logic        first_hit;
  logic        second_hit;

  assign first_hit  = (code == dig_first);
  assign second_hit = (code == dig_second);

  always_comb begin
    state_d = state_q;
    wr_en   = 2'b00;
    if (combo_rst) begin
      state_d = ST_IDLE;
    end else if (enter) begin
      unique case (state_q)
        ST_IDLE:      state_d = first_hit ? ST_FIRST_OK : ST_FIRST_BAD;
        ST_FIRST_OK:  state_d = second_hit ? ST_OPEN : ST_ERR;
        ST_FIRST_BAD: state_d = ST_ERR;
        ST_OPEN:      state_d = ST_PROG1;
        ST_ERR:       state_d = ST_IDLE;
        ST_PROG1: begin
          wr_en[0] = 1'b1;
          state_d  = ST_PROG2;
        end
        ST_PROG2: begin
          wr_en[1] = 1'b1;
          state_d  = ST_OPEN;
        end
        default:      state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  assign state = state_q;

endmodule

// File: rtl/lock_outdec.sv
module lock_outdec
  import combo_lock_pkg::*;
#(
  parameter int unsigned DIGIT_W = 2,
  localparam int unsigned DBG_W  = 2*DIGIT_W + ST_W + 1
) (
  input  lock_state_e        state,
  input  logic [DIGIT_W-1:0] dig_first,
  input  logic [DIGIT_W-1:0] dig_second,
  output logic               open,
  output logic               error,
  output logic               prog1,
  output logic               prog2,
  output logic [DBG_W-1:0]   dbg
);

  always_comb begin
    open  = (state == ST_OPEN);
    error = (state == ST_ERR);
    prog1 = (state == ST_PROG1);
    prog2 = (state == ST_PROG2);
    dbg   = {dig_first, dig_second, 1'b0, state};
  end

endmodule

// File: rtl/combo_lock_ctrl.sv
module combo_lock_ctrl
  import combo_lock_pkg::*;
#(
  parameter int unsigned DIGIT_W = 2,
  parameter logic [DIGIT_W-1:0] DEF_FIRST  = 2'b11,
  parameter logic [DIGIT_W-1:0] DEF_SECOND = 2'b01,
  localparam int unsigned DBG_W = 2*DIGIT_W + ST_W + 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [DIGIT_W-1:0] code,
  input  logic               enter,
  input  logic               combo_rst,
  output logic               open,
  output logic               error,
  output logic               prog1,
  output logic               prog2,
  output logic [DBG_W-1:0]   dbg
);

  localparam int unsigned NUM_DIGITS = 2;

  logic [NUM_DIGITS-1:0][DIGIT_W-1:0] digits;
  logic [NUM_DIGITS-1:0]              wr_en;
  lock_state_e                        state;

  combo_store #(
    .DIGIT_W    (DIGIT_W),
    .NUM_DIGITS (NUM_DIGITS),
    .DEF_COMBO  ({DEF_SECOND, DEF_FIRST})
  ) store_i (
    .clk       (clk),
    .combo_rst (combo_rst),
    .wr_en     (wr_en),
    .code      (code),
    .digits    (digits)
  );

  lock_fsm #(
    .DIGIT_W (DIGIT_W)
  ) fsm_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .enter      (enter),
    .combo_rst  (combo_rst),
    .code       (code),
    .dig_first  (digits[0]),
    .dig_second (digits[1]),
    .state      (state),
    .wr_en      (wr_en)
  );

  lock_outdec #(
    .DIGIT_W (DIGIT_W)
  ) dec_i (
    .state      (state),
    .dig_first  (digits[0]),
    .dig_second (digits[1]),
    .open       (open),
    .error      (error),
    .prog1      (prog1),
    .prog2      (prog2),
    .dbg        (dbg)
  );

endmodule

// File: rtl/combo_lock_chk.sv
module combo_lock_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] code,
  input logic       enter,
  input logic       combo_rst,
  input logic       open,
  input logic       error,
  input logic       prog1,
  input logic       prog2,
  input logic [7:0] dbg
);

  p_flags_onehot_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({open, error, prog1, prog2}));

  p_restore_r3: assert property (@(posedge clk) disable iff (!rst_n)
    combo_rst |=> (dbg[2:0] == 3'd0) && (dbg[7:4] == 4'b1101));

  p_error_needs_enter_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(error) |-> $past(enter));

  p_error_exit_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (error && enter && !combo_rst) |=> (!error && dbg[2:0] == 3'd0));

  p_open_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (open && !enter && !combo_rst) |=> open);

  p_open_to_prog_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (open && enter && !combo_rst) |=> prog1);

  p_prog_first_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (prog1 && enter && !combo_rst) |=> (prog2 && dbg[7:6] == $past(code)));

  p_prog_second_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (prog2 && enter && !combo_rst) |=> (open && dbg[5:4] == $past(code)));

  p_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!enter && !combo_rst) |=> $stable(dbg));

endmodule

bind combo_lock_ctrl combo_lock_chk chk_i (.*);

// File: tb/combo_lock_ctrl_tb_top.sv
module combo_lock_ctrl_tb_top;

  typedef struct {
    logic [11:0] val;
    string       tag;
  } exp_t;

  logic       clk;
  logic       rst_n;
  logic [1:0] code;
  logic       enter;
  logic       combo_rst;
  logic       open, error, prog1, prog2;
  logic [7:0] dbg;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  exp_t exp_q[$];
  event item_ev;

  logic [2:0] m_st;
  logic [1:0] m_d0, m_d1;

  combo_lock_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .code(code), .enter(enter),
    .combo_rst(combo_rst), .open(open), .error(error),
    .prog1(prog1), .prog2(prog2), .dbg(dbg)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic logic [11:0] model_out();
    return {m_st == 3'd3, m_st == 3'd4, m_st == 3'd5, m_st == 3'd6,
            m_d0, m_d1, 1'b0, m_st};
  endfunction

  task automatic push_exp(input string tag);
    exp_t e;
    e.val = model_out();
    e.tag = tag;
    exp_q.push_back(e);
    -> item_ev;
  endtask

  // Driver: one clock of stimulus, reference update, expected item.
  task automatic step(input logic [1:0] c, input bit e, input bit cr, input string tag);
    @(negedge clk);
    code = c; enter = e; combo_rst = cr;
    if (cr) begin
      m_st = 3'd0; m_d0 = 2'b11; m_d1 = 2'b01;
    end else if (e) begin
      case (m_st)
        3'd0: m_st = (c == m_d0) ? 3'd1 : 3'd2;
        3'd1: m_st = (c == m_d1) ? 3'd3 : 3'd4;
        3'd2: m_st = 3'd4;
        3'd3: m_st = 3'd5;
        3'd4: m_st = 3'd0;
        3'd5: begin m_d0 = c; m_st = 3'd6; end
        3'd6: begin m_d1 = c; m_st = 3'd3; end
        default: m_st = 3'd0;
      endcase
    end
    @(negedge clk);
    enter = 1'b0; combo_rst = 1'b0;
    push_exp(tag);
  endtask

  task automatic do_reset(input string tag);
    @(negedge clk);
    rst_n = 1'b0;
    m_st  = 3'd0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    push_exp(tag);
  endtask

  // Monitor: pops expected items and compares with the outputs.
  initial begin
    forever begin
      @(item_ev);
      #1;
      while (exp_q.size() > 0) begin
        exp_t e;
        logic [11:0] act;
        e = exp_q.pop_front();
        act = {open, error, prog1, prog2, dbg};
        checks++;
        if (act !== e.val) begin
          errors++;
          $display("FAIL %s: got %b expected %b", e.tag, act, e.val);
        end
      end
    end
  end

  initial begin
    #(8 * 20000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; code = 2'b00; enter = 1'b0; combo_rst = 1'b0;
    m_st = 3'd0; m_d0 = 2'b11; m_d1 = 2'b01;
    repeat (3) @(negedge clk);
    checks++;
    if ({open, error, prog1, prog2, dbg[3:0]} !== 8'b0) begin
      errors++;
      $display("FAIL R1: got %b expected %b", {open, error, prog1, prog2, dbg[3:0]}, 8'b0);
    end
    rst_n = 1'b1;
    step(2'b00, 0, 1, "R3 restore default");
    step(2'b11, 0, 0, "R11 code without enter");
    step(2'b10, 0, 0, "R11 code without enter");
    step(2'b11, 1, 0, "R4 first digit");
    step(2'b01, 1, 0, "R4 open");
    step(2'b00, 0, 0, "R8 open hold");
    step(2'b10, 0, 0, "R8 open hold");
    step(2'b11, 1, 0, "R8 enter programming");
    step(2'b00, 1, 0, "R9 store first");
    step(2'b10, 1, 0, "R9 store second");
    do_reset("R2 reset keeps digits");
    step(2'b11, 1, 0, "R9 old first now wrong");
    step(2'b01, 1, 0, "R5 error after second");
    step(2'b00, 0, 0, "R7 error hold");
    step(2'b00, 1, 0, "R7 error exit");
    step(2'b00, 1, 0, "R9 new first");
    step(2'b10, 1, 0, "R9 new pair opens");
    do_reset("R1 reset from open");
    step(2'b01, 1, 0, "R5 silent after wrong first");
    step(2'b10, 1, 0, "R5 error with right second");
    step(2'b00, 1, 0, "R7 exit");
    step(2'b00, 1, 0, "R6 first ok");
    step(2'b11, 1, 0, "R6 wrong second");
    step(2'b00, 1, 0, "R7 exit");
    step(2'b00, 1, 0, "R4 first");
    step(2'b10, 1, 0, "R4 open");
    step(2'b01, 1, 0, "R8 to prog1");
    step(2'b01, 1, 1, "R3 restore beats programming");
    step(2'b11, 1, 0, "R3 default first");
    step(2'b01, 1, 0, "R3 default opens");
    do_reset("R1 reset");
    step(2'b11, 1, 1, "R3 restore beats enter in idle");
    step(2'b11, 0, 0, "R10 idle quiet");
    @(negedge clk);
    @(negedge clk);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule